// File: doc/BRIEF.md
# Indirect Coefficient Store Port

This block gives a host byte-wide register access to an internal store of 24-bit filter and mixing coefficients. The store cannot be reached directly. The host first places a coefficient index in an index register. For a store operation it also fills a bank of fifteen staging bytes. It then writes a control register whose low four bits select one of four operations: store one coefficient, store a five-coefficient group, fetch one coefficient, or fetch a five-coefficient group. After a fetch, the host reads the result back from the staging bytes.

A five-coefficient group covers the indexed entry and the four entries that follow it, which is enough for a complete biquad section. The staging bank holds five 24-bit words, and each word sits in three adjacent bytes with its most significant byte first. In store order the words are b1, b2, a1, a2, b0. The upper four bits of the control register are reserved. The port keeps whatever was last written there and never alters them. The store has 62 entries: biquad groups in entries 0–39, the high-pass and low-pass groups in entries 40–49, and single scale and mix values in entries 50–61.

Register offsets: 0–14 are the staging bytes, with word k in bytes 3k..3k+2. Offset 15 is the index register and offset 16 is the control register. Other offsets read as zero.

Top module: `cram_port`

## Requirements
- R1: After reset every staging byte, the index register and the control register read 0, and `busy` and `err` are 0.
- R2: Staging bytes read back the last byte written. The index register keeps only its low 6 bits, so its upper two bits read 0.
- R3: Control bit 0 stores staging word 0 (bytes 0,1,2, MSB first) into the entry named by the index register.
- R4: Control bit 1 stores staging words 0..4 into entries index..index+4, word k going to entry index+k.
- R5: Control bit 2 loads the indexed entry into staging bytes 0..2 and leaves bytes 3..14 unchanged.
- R6: Control bit 3 loads entries index..index+4 into staging words 0..4.
- R7: Control bits 7..4 read back as last written, whatever command runs. Command bits 3..0 read 0 once the operation has finished.
- R8: `busy` rises on the clock edge that accepts a command. It stays high for exactly 1 cycle for a single-entry command and exactly 5 cycles for a group command.
- R9: Register writes made while `busy` is high have no effect.
- R10: A group command whose index plus 4 exceeds 61 is rejected. Nothing is stored, `busy` stays low and `err` goes to 1.
- R11: With an index of 62 or more, every command is rejected in the same way.
- R12: When several command bits are set in one write, only the lowest-numbered one is carried out.
- R13: An accepted command clears `err`. A control write with no command bit set leaves `err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 5 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_off`) |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last command was rejected |

## Verification
The checker assumes that the host changes `reg_off`, `reg_wdata` and `reg_wr` only between clock edges. It also assumes that a control write comes only after the index register has settled, because the range check reads the stored index on the same edge as the command. The bench drives every input on the falling edge. It writes the index and staging bytes in separate cycles before the control write. Except for the one scenario that deliberately tests writes made while `busy` is high, it waits for `busy` to fall before the next access.

// File: rtl/cram_pkg.sv
package cram_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_WR1  = 3'd1,
        CMD_WR5  = 3'd2,
        CMD_RD1  = 3'd3,
        CMD_RD5  = 3'd4
    } cmd_e;

    localparam int CTL_BIT_WR1 = 0;
    localparam int CTL_BIT_WR5 = 1;
    localparam int CTL_BIT_RD1 = 2;
    localparam int CTL_BIT_RD5 = 3;

    function automatic logic cmd_is_group(cmd_e c);
        return (c == CMD_WR5) || (c == CMD_RD5);
    endfunction

    function automatic logic cmd_is_store(cmd_e c);
        return (c == CMD_WR1) || (c == CMD_WR5);
    endfunction

    function automatic logic cmd_is_fetch(cmd_e c);
        return (c == CMD_RD1) || (c == CMD_RD5);
    endfunction

endpackage

// File: rtl/cram_store.sv
module cram_store #(
    parameter int COEF_W   = 24,
    parameter int NUM_COEF = 62,
    parameter int ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [COEF_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [COEF_W-1:0] rdata
);

    logic [COEF_W-1:0] ent_q [NUM_COEF];

    for (genvar e = 0; e < NUM_COEF; e++) begin : g_ent
        logic hit;
        assign hit = we && (waddr == ADDR_W'(e));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[e] <= '0;
            end else if (hit) begin
                ent_q[e] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(raddr) < NUM_COEF) begin
            rdata = ent_q[raddr];
        end
    end

endmodule

// File: rtl/cram_seq.sv
module cram_seq #(
    parameter int ADDR_W  = 6,
    parameter int BLK_LEN = 5,
    parameter int LEN_W   = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  cram_pkg::cmd_e      start_cmd,
    input  logic [ADDR_W-1:0]   start_base,
    output logic                busy,
    output logic                wr_en,
    output logic                rd_en,
    output logic [LEN_W-1:0]    word_idx,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                done
);
    import cram_pkg::*;

    typedef struct packed {
        logic              active;
        cmd_e              cmd;
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  idx;
    } seq_t;

    seq_t st_d, st_q;
    logic [LEN_W-1:0] last_idx;

    always_comb begin
        st_d     = st_q;
        last_idx = cmd_is_group(st_q.cmd) ? LEN_W'(BLK_LEN - 1) : '0;
        busy     = st_q.active;
        wr_en    = st_q.active && cmd_is_store(st_q.cmd);
        rd_en    = st_q.active && cmd_is_fetch(st_q.cmd);
        word_idx = st_q.idx;
        mem_addr = st_q.base + ADDR_W'(st_q.idx);
        done     = st_q.active && (st_q.idx == last_idx);

        if (st_q.active) begin
            if (st_q.idx == last_idx) begin
                st_d.active = 1'b0;
                st_d.cmd    = CMD_NONE;
                st_d.idx    = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (start) begin
            st_d.active = 1'b1;
            st_d.cmd    = start_cmd;
            st_d.base   = start_base;
            st_d.idx    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, cmd: CMD_NONE, base: '0, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cram_port.sv
module cram_port #(
    parameter int COEF_W   = 24,
    parameter int NUM_COEF = 62,
    parameter int BLK_LEN  = 5,
    parameter int BYTE_W   = 8,
    parameter int BPC      = COEF_W / BYTE_W,
    parameter int STAGE_B  = BPC * BLK_LEN,
    parameter int ADDR_W   = $clog2(NUM_COEF),
    parameter int REG_AW   = $clog2(STAGE_B + 2),
    parameter int LEN_W    = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_off,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              busy,
    output logic              err
);
    import cram_pkg::*;

    localparam int OFF_INDEX = STAGE_B;
    localparam int OFF_CTL   = STAGE_B + 1;
    localparam int CMD_BITS  = 4;
    localparam int RSV_BITS  = BYTE_W - CMD_BITS;
    localparam int LAST_GRP  = NUM_COEF - BLK_LEN;

    typedef struct packed {
        logic [STAGE_B-1:0][BYTE_W-1:0] stage;
        logic [ADDR_W-1:0]              base;
        logic [RSV_BITS-1:0]            rsv;
        logic [CMD_BITS-1:0]            cmd;
        logic                           err;
    } regs_t;

    regs_t st_d, st_q;

    logic              seq_start;
    cmd_e              seq_cmd;
    logic              seq_busy;
    logic              seq_wr;
    logic              seq_rd;
    logic [LEN_W-1:0]  seq_idx;
    logic [ADDR_W-1:0] seq_addr;
    logic              seq_done;
    logic [COEF_W-1:0] mem_wword;
    logic [COEF_W-1:0] mem_rword;

    cram_seq #(
        .ADDR_W  (ADDR_W),
        .BLK_LEN (BLK_LEN),
        .LEN_W   (LEN_W)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (seq_start),
        .start_cmd  (seq_cmd),
        .start_base (st_q.base),
        .busy       (seq_busy),
        .wr_en      (seq_wr),
        .rd_en      (seq_rd),
        .word_idx   (seq_idx),
        .mem_addr   (seq_addr),
        .done       (seq_done)
    );

    cram_store #(
        .COEF_W   (COEF_W),
        .NUM_COEF (NUM_COEF),
        .ADDR_W   (ADDR_W)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seq_wr),
        .waddr (seq_addr),
        .wdata (mem_wword),
        .raddr (seq_addr),
        .rdata (mem_rword)
    );

    // Staging word selected by the sequencer, assembled MSB first
    always_comb begin
        mem_wword = '0;
        for (int b = 0; b < BPC; b++) begin
            mem_wword[COEF_W-1-BYTE_W*b -: BYTE_W] = st_q.stage[int'(seq_idx)*BPC + b];
        end
    end

    // Next-state logic: host writes, command decode, fetch capture
    always_comb begin
        logic           idx_ok;
        logic           grp_ok;
        logic [CMD_BITS-1:0] req;
        cmd_e           pick;
        logic [CMD_BITS-1:0] pick_oh;

        st_d      = st_q;
        seq_start = 1'b0;
        seq_cmd   = CMD_NONE;
        req       = reg_wdata[CMD_BITS-1:0];
        idx_ok    = int'(st_q.base) < NUM_COEF;
        grp_ok    = int'(st_q.base) <= LAST_GRP;
        pick      = CMD_NONE;
        pick_oh   = '0;

        // lowest set bit wins
        if (req[CTL_BIT_WR1]) begin
            pick = CMD_WR1; pick_oh[CTL_BIT_WR1] = 1'b1;
        end else if (req[CTL_BIT_WR5]) begin
            pick = CMD_WR5; pick_oh[CTL_BIT_WR5] = 1'b1;
        end else if (req[CTL_BIT_RD1]) begin
            pick = CMD_RD1; pick_oh[CTL_BIT_RD1] = 1'b1;
        end else if (req[CTL_BIT_RD5]) begin
            pick = CMD_RD5; pick_oh[CTL_BIT_RD5] = 1'b1;
        end

        if (seq_busy) begin
            if (seq_rd) begin
                for (int b = 0; b < BPC; b++) begin
                    st_d.stage[int'(seq_idx)*BPC + b] = mem_rword[COEF_W-1-BYTE_W*b -: BYTE_W];
                end
            end
            if (seq_done) begin
                st_d.cmd = '0;
            end
        end else if (reg_wr) begin
            if (int'(reg_off) < STAGE_B) begin
                st_d.stage[reg_off] = reg_wdata;
            end else if (int'(reg_off) == OFF_INDEX) begin
                st_d.base = reg_wdata[ADDR_W-1:0];
            end else if (int'(reg_off) == OFF_CTL) begin
                st_d.rsv = reg_wdata[BYTE_W-1:CMD_BITS];
                if (pick != CMD_NONE) begin
                    if (idx_ok && (grp_ok || !cmd_is_group(pick))) begin
                        seq_start = 1'b1;
                        seq_cmd   = pick;
                        st_d.cmd  = pick_oh;
                        st_d.err  = 1'b0;
                    end else begin
                        st_d.cmd  = '0;
                        st_d.err  = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Host read mux
    always_comb begin
        reg_rdata = '0;
        if (int'(reg_off) < STAGE_B) begin
            reg_rdata = st_q.stage[reg_off];
        end else if (int'(reg_off) == OFF_INDEX) begin
            reg_rdata = BYTE_W'(st_q.base);
        end else if (int'(reg_off) == OFF_CTL) begin
            reg_rdata = {st_q.rsv, st_q.cmd};
        end
    end

    assign busy = seq_busy;
    assign err  = st_q.err;

endmodule

// File: rtl/cram_port_chk.sv
module cram_port_chk #(
    parameter int NUM_COEF = 62,
    parameter int BLK_LEN  = 5,
    parameter int STAGE_B  = 15,
    parameter int ADDR_W   = 6,
    parameter int REG_AW   = 5,
    parameter int RSV_BITS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [REG_AW-1:0]   reg_off,
    input logic [7:0]          reg_wdata,
    input logic                busy,
    input logic                err,
    input logic [ADDR_W-1:0]   base_q,
    input logic [RSV_BITS-1:0] rsv_q
);
    localparam int CNT_W = $clog2(BLK_LEN + 2);

    logic [CNT_W-1:0] busy_cnt;
    logic             ctl_wr;

    assign ctl_wr = reg_wr && !busy && (int'(reg_off) == STAGE_B + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    // R8
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(busy_cnt) < BLK_LEN));

    // R7
    rsv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(rsv_q));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr) |=> $stable(base_q));

    // R10
    group_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !reg_wdata[0] && reg_wdata[1] && (int'(base_q) > NUM_COEF - BLK_LEN))
        |=> (!busy && err));

    // R13
    start_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !err);

endmodule

bind cram_port cram_port_chk #(
    .NUM_COEF (NUM_COEF),
    .BLK_LEN  (BLK_LEN),
    .STAGE_B  (STAGE_B),
    .ADDR_W   (ADDR_W),
    .REG_AW   (REG_AW),
    .RSV_BITS (RSV_BITS)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_off   (reg_off),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .err       (err),
    .base_q    (st_q.base),
    .rsv_q     (st_q.rsv)
);

// File: tb/test_cram_port.sv
module test_cram_port;

    localparam int OFF_INDEX = 15;
    localparam int OFF_CTL   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_off = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       busy;
    logic       err;

    int n_vec  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cram_port i_cram_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_off   (reg_off),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .err       (err)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(int off, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_off = 5'(off); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int off, output logic [7:0] d);
        reg_off = 5'(off);
        #1;
        d = reg_rdata;
    endtask

    task automatic set_word(int k, logic [23:0] v);
        wr(3*k,   v[23:16]);
        wr(3*k+1, v[15:8]);
        wr(3*k+2, v[7:0]);
    endtask

    task automatic get_word(int k, output logic [23:0] v);
        logic [7:0] a, b, c;
        rd(3*k, a); rd(3*k+1, b); rd(3*k+2, c);
        v = {a, b, c};
    endtask

    // Counts busy cycles; first busy cycle already seen on return of wr()
    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (busy && cycles < 20) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    function automatic logic [23:0] pat(int k);
        return 24'hA10000 + 24'(k) * 24'h010203;
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        check("R1 busy", 32'(busy), 0);
        check("R1 err", 32'(err), 0);
        for (int i = 0; i <= OFF_CTL; i++) begin
            rd(i, d);
            check("R1 register", 32'(d), 0);
        end
    endtask

    task automatic t_readback();
        logic [7:0] d;
        wr(7, 8'h5C); rd(7, d); check("R2 stage byte", 32'(d), 32'h5C);
        wr(OFF_INDEX, 8'hFF); rd(OFF_INDEX, d); check("R2 index mask", 32'(d), 32'h3F);
    endtask

    task automatic t_group_store_fetch();
        logic [23:0] v;
        int c;
        for (int k = 0; k < 5; k++) set_word(k, pat(k));
        wr(OFF_INDEX, 8'd20);
        wr(OFF_CTL, 8'h02);
        wait_idle(c);
        check("R8 group busy cycles", 32'(c), 5);
        for (int k = 0; k < 5; k++) set_word(k, 24'h0);
        wr(OFF_CTL, 8'h08);
        wait_idle(c);
        check("R8 group fetch cycles", 32'(c), 5);
        for (int k = 0; k < 5; k++) begin
            get_word(k, v);
            check("R4 R6 group word", 32'(v), 32'(pat(k)));
        end
        // single fetch of entry 22 shows word 2 landed at index+2
        for (int k = 0; k < 5; k++) set_word(k, 24'h0);
        wr(OFF_INDEX, 8'd22);
        wr(OFF_CTL, 8'h04);
        wait_idle(c);
        get_word(0, v);
        check("R4 entry 22", 32'(v), 32'(pat(2)));
    endtask

    task automatic t_single();
        logic [23:0] v;
        int c;
        set_word(0, 24'h123456);
        wr(OFF_INDEX, 8'd55);
        wr(OFF_CTL, 8'h01);
        wait_idle(c);
        check("R8 single busy cycles", 32'(c), 1);
        set_word(0, 24'h0);
        set_word(1, 24'hBEEF01);
        wr(OFF_CTL, 8'h04);
        wait_idle(c);
        get_word(0, v);
        check("R3 R5 single fetch", 32'(v), 32'h123456);
        get_word(1, v);
        check("R5 word1 untouched", 32'(v), 32'hBEEF01);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        int c;
        wr(OFF_INDEX, 8'd55);
        wr(OFF_CTL, 8'hA4);
        rd(OFF_CTL, d);
        check("R7 cmd visible while busy", 32'(d), 32'hA4);
        wait_idle(c);
        rd(OFF_CTL, d);
        check("R7 self clear keeps reserved", 32'(d), 32'hA0);
        wr(OFF_CTL, 8'h50);
        rd(OFF_CTL, d);
        check("R7 reserved only", 32'(d), 32'h50);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d;
        int c;
        wr(OFF_INDEX, 8'd20);
        wr(OFF_CTL, 8'h08);
        wr(OFF_INDEX, 8'd7);
        wr(5, 8'h77);
        wait_idle(c);
        rd(OFF_INDEX, d);
        check("R9 index unchanged", 32'(d), 20);
        rd(5, d);
        check("R9 stage byte from fetch", 32'(d), 32'(pat(1) & 24'hFF));
    endtask

    task automatic t_range();
        logic [23:0] v;
        int c;
        set_word(0, 24'hFACE01);
        wr(OFF_INDEX, 8'd58);
        wr(OFF_CTL, 8'h02);
        check("R10 busy stays low", 32'(busy), 0);
        check("R10 err set", 32'(err), 1);
        wr(OFF_CTL, 8'h00);
        check("R13 err kept by empty write", 32'(err), 1);
        wr(OFF_CTL, 8'h04);
        check("R13 err cleared", 32'(err), 0);
        wait_idle(c);
        get_word(0, v);
        check("R10 entry 58 untouched", 32'(v), 0);
        wr(OFF_INDEX, 8'd57);
        wr(OFF_CTL, 8'h08);
        check("R10 index 57 accepted", 32'(busy), 1);
        wait_idle(c);
    endtask

    task automatic t_bad_index();
        logic [7:0] d;
        wr(OFF_INDEX, 8'd62);
        wr(OFF_CTL, 8'h01);
        check("R11 single rejected busy", 32'(busy), 0);
        check("R11 single rejected err", 32'(err), 1);
        wr(OFF_CTL, 8'h04);
        check("R11 fetch rejected", 32'(busy), 0);
        rd(OFF_CTL, d);
        check("R11 cmd bits clear", 32'(d & 8'h0F), 0);
    endtask

    task automatic t_priority();
        logic [23:0] v;
        int c;
        wr(OFF_INDEX, 8'd20);
        set_word(1, 24'h0F0F0F);
        wr(OFF_CTL, 8'h0C);
        wait_idle(c);
        check("R12 fetch1 over fetch5 cycles", 32'(c), 1);
        get_word(1, v);
        check("R12 word1 untouched", 32'(v), 32'h0F0F0F);
        wr(OFF_CTL, 8'h03);
        wait_idle(c);
        check("R12 store1 over store5 cycles", 32'(c), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_group_store_fetch();
        t_single();
        t_reserved();
        t_busy_ignore();
        t_range();
        t_bad_index();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule